// File: doc/BRIEF.md
# Differential PSK Symbol Demapper

This block turns a stream of phase samples into data words for a receiver of partial-circle differential phase-shift keying. A time-to-digital converter delivers one signed 8-bit phase code per symbol together with a valid strobe. The data sits in the phase change between two consecutive symbols. For each sample after the first, the block therefore takes the current code minus the previous one. It rounds that difference to the nearest whole number of constellation steps and clamps the result to the point range of the selected order. It then turns the resulting Gray-coded point index back into plain binary.

The points lie on a narrow arc: 4 degrees apart in the 16-point mode and 8 degrees apart in the 8-point mode. The converter resolves about 0.45 degrees per code, so the step is supplied as a number of converter codes: about 9 for 16 points and about 18 for 8 points. In the 16-point mode, at a symbol rate of a quarter of a 13.56 MHz carrier, each symbol carries 4 bits and the link runs at 13.56 Mbps. In the 8-point mode each symbol carries 3 bits, giving 10.17 Mbps. A frame-start pulse discards the stored reference phase, so that a new frame begins cleanly.

Top module: `dpsk_demapper`

## Requirements
- R1: While reset is low, and on the first cycle after it, `sym_valid` is 0 and `sym_bits` is 0.
- R2: The first valid sample after reset is not turned into a word. It only becomes the reference phase, and `sym_valid` stays 0 in the following cycle.
- R3: Each later valid sample produces `sym_valid`=1 exactly one clock after it. Cycles without a valid sample produce `sym_valid`=0 and leave the reference phase unchanged.
- R4: The phase difference is the current sample minus the reference, computed over 9 signed bits. It therefore does not wrap: 127 after -128 gives +255, and -128 after 127 gives -255.
- R5: The difference d is rounded to the nearest multiple k of `step_lsb`. Ties round toward positive, so k = floor((2d + step) / (2*step)).
- R6: The point index is k + N/2, clamped to the range 0..N-1, where N is 8 or 16. The most negative point therefore maps to index 0.
- R7: The point index is treated as a Gray code. The output is its binary value: output bit b is the XOR of index bits b and above.
- R8: `mode`=0 selects 8 points and 3-bit words, with `sym_bits[3]` always 0. `mode`=1 selects 16 points and 4-bit words.
- R9: A `frame_start` pulse discards the reference phase. The next valid sample is treated as a first sample as in R2. When `frame_start` and `sample_valid` are high in the same cycle, that sample is the new first sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Discard the reference phase; the next sample starts a new frame |
| sample_valid | input | 1 | Phase sample present this cycle |
| sample | input | 8 | Signed phase code from the converter |
| mode | input | 1 | 0 = 8 points, 1 = 16 points |
| step_lsb | input | 6 | Constellation step in converter codes |
| sym_valid | output | 1 | Data word valid |
| sym_bits | output | 4 | Recovered data word, binary |

## Verification
A stale or corrupted reference phase would show up on the very next output word. That word would be off by the size of the error, divided by the step, and would then look correct again one symbol later, because the reference is reloaded from each sample. A wrong first-sample flag would show as an extra or a missing `sym_valid` one cycle after the first sample of a frame. A slicing or Gray error would show as a wrong word in the cycle after the sample, most likely on samples at the rounding thresholds and at the clamp limits. The bench therefore drives exact ties, differences larger than the arc at both ends, gaps in the valid strobe and frame restarts, and compares each word with a model written from the requirements.

// File: rtl/dpsk_pkg.sv
// Shared widths and the mode encoding for the differential PSK demapper.
package dpsk_pkg;
    typedef enum logic {
        MODE_8PT  = 1'b0,
        MODE_16PT = 1'b1
    } psk_mode_e;

    localparam int SAMPLE_W = 8;             // converter code width
    localparam int DIFF_W   = SAMPLE_W + 1;  // difference width, cannot wrap
    localparam int STEP_W   = 6;             // step register width
    localparam int WORD_W   = 4;             // widest data word
    localparam int NPTS_MAX = 1 << WORD_W;   // points in the widest mode
endpackage

// File: rtl/dpsk_diff_stage.sv
// Holds the reference phase and forms the current-minus-previous difference.
// Assumes at most one sample per clock; frame_start only clears the reference flag.
module dpsk_diff_stage
    import dpsk_pkg::*;
#(
    parameter int SW = SAMPLE_W,
    parameter int DW = SW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 sample_valid,
    input  logic signed [SW-1:0] sample,
    output logic signed [DW-1:0] diff,
    output logic                 fire
);
    logic signed [SW-1:0] ref_q;
    logic                 have_ref_q;

    // Reference register: loaded by every valid sample, flag cleared on frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q      <= '0;
            have_ref_q <= 1'b0;
        end else if (sample_valid) begin
            ref_q      <= sample;
            have_ref_q <= 1'b1;
        end else if (frame_start) begin
            have_ref_q <= 1'b0;
        end
    end

    // Sign-extended subtraction, one bit wider than the samples.
    always_comb begin
        diff = DW'(sample) - DW'(ref_q);
        fire = sample_valid && have_ref_q && !frame_start;
    end

    // R2
    ref_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> have_ref_q);

    // R9
    frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !sample_valid) |=> !have_ref_q);
endmodule

// File: rtl/dpsk_slicer.sv
// Rounds a phase difference to the nearest step multiple and offsets it into
// a point index 0..N-1. One comparator per decision threshold, for each mode;
// the index is the count of thresholds reached, so clamping needs no extra logic.
module dpsk_slicer
    import dpsk_pkg::*;
#(
    parameter int DW    = DIFF_W,
    parameter int STW   = STEP_W,
    parameter int WW    = WORD_W,
    localparam int NMAX  = 1 << WW,
    localparam int CMP_W = DW + STW + 3
) (
    input  logic signed [DW-1:0] diff,
    input  logic [STW-1:0]       step_lsb,
    input  psk_mode_e            mode,
    output logic [WW-1:0]        index
);
    logic signed [CMP_W-1:0] twice_d;
    logic signed [CMP_W-1:0] step_s;
    logic [NMAX-1:1]         hit_wide;
    logic [NMAX-1:1]         hit_narrow;

    // Doubled difference and the step widened for signed products.
    always_comb begin
        twice_d = CMP_W'(diff) <<< 1;
        step_s  = signed'(CMP_W'(step_lsb));
    end

    // Threshold i sits halfway below point i: (2*(i - N/2) - 1) * step.
    for (genvar i = 1; i < NMAX; i++) begin : g_thr
        localparam logic signed [CMP_W-1:0] KW = CMP_W'(2 * (i - NMAX / 2) - 1);
        assign hit_wide[i] = twice_d >= step_s * KW;
        if (i < NMAX / 2) begin : g_narrow
            localparam logic signed [CMP_W-1:0] KN = CMP_W'(2 * (i - NMAX / 4) - 1);
            assign hit_narrow[i] = twice_d >= step_s * KN;
        end else begin : g_none
            assign hit_narrow[i] = 1'b0;
        end
    end

    // Count the thresholds reached in the selected mode.
    always_comb begin
        index = '0;
        for (int i = 1; i < NMAX; i++) begin
            if (mode == MODE_16PT ? hit_wide[i] : hit_narrow[i])
                index = index + WW'(1);
        end
    end

    // R6
    always_comb begin
        if (mode == MODE_8PT)
            narrow_range_chk: assert (index < WW'(NMAX / 2));
    end
endmodule

// File: rtl/dpsk_gray_dec.sv
// Gray-to-binary conversion: each binary bit is the XOR of its Gray bit and all above.
module dpsk_gray_dec #(
    parameter int WW = dpsk_pkg::WORD_W
) (
    input  logic [WW-1:0] gray,
    output logic [WW-1:0] bin
);
    for (genvar b = 0; b < WW; b++) begin : g_bit
        assign bin[b] = ^(gray >> b);
    end
endmodule

// File: rtl/dpsk_demapper.sv
// Differential PSK demapper top: difference, slice, Gray decode, one output register.
// Assumes samples are signed converter codes and step_lsb is nonzero while data flows.
module dpsk_demapper
    import dpsk_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_start,
    input  logic                       sample_valid,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic                       mode,
    input  logic [STEP_W-1:0]          step_lsb,
    output logic                       sym_valid,
    output logic [WORD_W-1:0]          sym_bits
);
    logic signed [DIFF_W-1:0] diff;
    logic                     fire;
    logic [WORD_W-1:0]        index;
    logic [WORD_W-1:0]        word;

    dpsk_diff_stage #(.SW(SAMPLE_W), .DW(DIFF_W)) u_diff (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .sample_valid(sample_valid), .sample(sample),
        .diff(diff), .fire(fire)
    );

    dpsk_slicer #(.DW(DIFF_W), .STW(STEP_W), .WW(WORD_W)) u_slice (
        .diff(diff), .step_lsb(step_lsb), .mode(psk_mode_e'(mode)), .index(index)
    );

    dpsk_gray_dec #(.WW(WORD_W)) u_gray (.gray(index), .bin(word));

    // Output register: one cycle of latency, the word is held between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_valid <= 1'b0;
            sym_bits  <= '0;
        end else begin
            sym_valid <= fire;
            if (fire) sym_bits <= word;
        end
    end

    // R3
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> $past(sample_valid));

    // R8
    narrow_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !$past(mode)) |-> !sym_bits[WORD_W-1]);

    // R9
    restart_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !sym_valid);
endmodule

// File: tb/tb_dpsk_demapper.sv
module tb_dpsk_demapper;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0;
    logic              sample_valid = 1'b0;
    logic signed [7:0] sample = '0;
    logic              mode = 1'b1;
    logic [5:0]        step_lsb = 6'd9;
    logic              sym_valid;
    logic [3:0]        sym_bits;

    int checks = 0;
    int fails  = 0;
    logic signed [7:0] ref_m;
    bit                have_m;
    logic [3:0]        last_word;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dpsk_demapper dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .sample_valid(sample_valid), .sample(sample), .mode(mode),
        .step_lsb(step_lsb), .sym_valid(sym_valid), .sym_bits(sym_bits)
    );

    // Vector row: {start, mode, step[5:0], sample[7:0]}
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 6'd9,  8'sd0},
        {1'b0, 1'b1, 6'd9,  8'sd9},
        {1'b0, 1'b1, 6'd9,  8'sd23},
        {1'b0, 1'b1, 6'd9,  8'sd18},
        {1'b0, 1'b1, 6'd9,  -8'sd40},
        {1'b0, 1'b1, 6'd9,  -8'sd45},
        {1'b0, 1'b1, 6'd9,  8'sd100},
        {1'b0, 1'b1, 6'd9,  -8'sd128},
        {1'b0, 1'b1, 6'd9,  8'sd127},
        {1'b1, 1'b0, 6'd18, 8'sd10},
        {1'b0, 1'b0, 6'd18, 8'sd28},
        {1'b0, 1'b0, 6'd18, 8'sd19},
        {1'b0, 1'b0, 6'd18, -8'sd40},
        {1'b0, 1'b0, 6'd18, -8'sd20},
        {1'b0, 1'b0, 6'd18, 8'sd90},
        {1'b0, 1'b0, 6'd18, -8'sd90}
    };

    // Expected word from the requirements: nearest step, offset, clamp, Gray to binary.
    function automatic logic [3:0] model(input int d, input int st, input bit m16);
        int num, den, k, half, idx;
        logic [3:0] g, b;
        num = 2 * d + st;
        den = 2 * st;
        k = num / den;
        if ((num % den) != 0 && num < 0) k = k - 1;
        half = m16 ? 8 : 4;
        idx = k + half;
        if (idx < 0) idx = 0;
        if (idx > 2 * half - 1) idx = 2 * half - 1;
        g = 4'(idx);
        for (int i = 0; i < 4; i++) b[i] = ^(g >> i);
        return b;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one sample at a falling edge, check the outputs one clock later.
    task automatic send(input logic signed [7:0] s, input bit start, input string req);
        bit exp_v;
        logic [3:0] exp_w;
        exp_v = have_m && !start;
        exp_w = exp_v ? model(int'(s) - int'(ref_m), int'(step_lsb), mode) : last_word;
        sample = s; sample_valid = 1'b1; frame_start = start;
        @(negedge clk);
        sample_valid = 1'b0; frame_start = 1'b0;
        check(sym_valid == exp_v, req, int'(sym_valid), int'(exp_v));
        if (exp_v) check(sym_bits == exp_w, req, int'(sym_bits), int'(exp_w));
        if (exp_v) last_word = exp_w;
        ref_m = s; have_m = 1'b1;
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(sym_valid == 1'b0, req, int'(sym_valid), 0);
        end
    endtask

    initial begin
        have_m = 1'b0; ref_m = '0; last_word = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(sym_valid == 1'b0, "R1", int'(sym_valid), 0);
        check(sym_bits == 4'd0, "R1", int'(sym_bits), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sym_valid == 1'b0 && sym_bits == 4'd0, "R1", int'(sym_bits), 0);

        // R2 first sample after reset gives no word
        send(8'sd5, 1'b0, "R2");
        // R5 exact ties round toward positive (step 10: +5 -> k=1, -5 -> k=0)
        step_lsb = 6'd10;
        send(8'sd10, 1'b0, "R5");
        send(8'sd5, 1'b0, "R5");
        // R3 gaps keep the reference, output silent between strobes
        idle(3, "R3");
        send(8'sd25, 1'b0, "R3");
        // R4 full-range swings do not wrap, R6 clamps at both ends
        send(-8'sd128, 1'b0, "R4");
        send(8'sd127, 1'b0, "R4");
        send(-8'sd128, 1'b0, "R6");
        // R9 frame_start alone drops the reference
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        check(sym_valid == 1'b0, "R9", int'(sym_valid), 0);
        have_m = 1'b0;
        send(8'sd50, 1'b0, "R9");
        send(8'sd60, 1'b0, "R9");

        // R7 R8 table: both modes, several patterns; starts with frame_start+valid (R9)
        for (int v = 0; v < NVEC; v++) begin
            mode = VEC[v][14];
            step_lsb = VEC[v][13:8];
            send(signed'(VEC[v][7:0]), VEC[v][15], VEC[v][15] ? "R9" : (VEC[v][14] ? "R7" : "R8"));
            if (!VEC[v][14] && sym_valid)
                check(sym_bits[3] == 1'b0, "R8", int'(sym_bits[3]), 0);
        end
        // R3 back-to-back strobes after the table
        send(-8'sd70, 1'b0, "R3");
        idle(1, "R3");
        // R1 reset in mid-stream clears outputs and reference
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sym_valid == 1'b0 && sym_bits == 4'd0, "R1", int'(sym_bits), 0);
        have_m = 1'b0; last_word = '0;
        send(8'sd0, 1'b0, "R2");
        send(-8'sd18, 1'b0, "R6");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule